// File: doc/BRIEF.md
# Sequential Modulo Power-of-Two Exponentiator

This block raises a base to an exponent and keeps only the low `WIDTH` bits of the result, which is the same as reducing it modulo 2^WIDTH. Each operand has its own signedness flag. When a flag is set, the operand's top bit has negative weight. When it is clear, the operand is read as a plain unsigned number.

A request is taken on `start_i` while the unit is idle, and the operands are captured on that edge. Some operand combinations have a closed-form answer: a zero base, a zero exponent, or a negative exponent. These are resolved straight away. All other requests run through a square-and-multiply loop that consumes one exponent bit per clock cycle. A negative base enters the loop as its magnitude, and the result is negated at the end when the exponent is odd. `done_o` pulses for one cycle when the answer is ready. `result_o` and `undef_o` hold that answer until the next completion.

Top module: `seq_int_pow`

## Requirements
- R1: With `base_signed_i` (or `exp_signed_i`) high, bit WIDTH-1 of that operand weighs -2^(WIDTH-1). With the flag low, the operand is unsigned.
- R2: A zero base with a negative exponent gives `undef_o`=1 and `result_o`=0. Every other request gives `undef_o`=0.
- R3: A zero exponent gives 1, including when the base is zero. A zero base with a positive exponent gives 0.
- R4: With a negative exponent, the result depends on the base. A base of +1 gives 1. A base of -1 gives 1 for an even exponent and all ones (-1) for an odd exponent. Any base of magnitude two or more gives 0.
- R5: With a positive exponent and a nonzero base, `result_o` equals base^exponent mod 2^WIDTH in two's complement, including for negative bases.
- R6: `done_o` rises exactly L+2 rising edges after the edge that accepts `start_i`, counting the accepting edge as the first. L is the bit length of the exponent when R5 applies, and 0 otherwise.
- R7: `done_o` is high for exactly one cycle. `busy_o` is high from the accepting edge until the edge that raises `done_o`, and is low while `done_o` is high.
- R8: `start_i` and operand changes have no effect while `busy_o` is high. The result still belongs to the request that was accepted.
- R9: `result_o` and `undef_o` change only on the edge that raises `done_o`.
- R10: After reset, `busy_o`, `done_o`, `undef_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; taken when the unit is idle |
| base_i | input | WIDTH | Base operand |
| exp_i | input | WIDTH | Exponent operand |
| base_signed_i | input | 1 | Read the base as two's complement |
| exp_signed_i | input | 1 | Read the exponent as two's complement |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Low WIDTH bits of the power |
| undef_o | output | 1 | The last result has no defined value |

## Verification
The answer to a closed-form request is due two rising edges after the accepting edge. A request that runs the loop needs one more edge for each bit of the exponent's length. The bench counts edges from the accepting one and samples on the falling edge. It requires `done_o` to appear on exactly the predicted count. It checks the value and `undef_o` in that same half-cycle, and `busy_o` on every falling edge before it. Expected values come from plain repeated multiplication modulo 2^WIDTH over every base, exponent and flag combination.

// File: rtl/ipow_pkg.sv
package ipow_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOP = 2'd1,
      ST_FIN  = 2'd2
   } ipow_state_e;

   typedef enum int {
      MUL_NATIVE   = 0,
      MUL_SHIFTADD = 1
   } ipow_mul_e;
endpackage

// File: rtl/ipow_decode.sv
module ipow_decode #(
   parameter int W = 16
) (
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] exp_i,
   input  logic         base_sgn_i,
   input  logic         exp_sgn_i,
   output logic         iter_o,
   output logic [W-1:0] fixed_o,
   output logic         undef_o,
   output logic [W-1:0] mag_o,
   output logic [W-1:0] pow_o,
   output logic         flip_o
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ALL1 = '1;

   logic base_neg, exp_neg, base_zero, exp_zero;

   assign base_neg  = base_sgn_i & base_i[W-1];
   assign exp_neg   = exp_sgn_i & exp_i[W-1];
   assign base_zero = (base_i == '0);
   assign exp_zero  = (exp_i == '0);

   always_comb begin
      iter_o  = 1'b0;
      fixed_o = '0;
      undef_o = 1'b0;
      mag_o   = base_neg ? (~base_i + ONE) : base_i;
      pow_o   = exp_i;
      flip_o  = base_neg & exp_i[0];
      if (base_zero && exp_neg) begin
         undef_o = 1'b1;
      end else if (exp_zero) begin
         fixed_o = ONE;
      end else if (base_zero) begin
         fixed_o = '0;
      end else if (exp_neg) begin
         if (base_i == ONE)
            fixed_o = ONE;
         else if (base_neg && base_i == ALL1)
            fixed_o = exp_i[0] ? ALL1 : ONE;
         else
            fixed_o = '0;
      end else begin
         iter_o = 1'b1;
      end
   end
endmodule

// File: rtl/ipow_mul.sv
module ipow_mul #(
   parameter int W    = 16,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] p_o
);
   generate
      if (IMPL == ipow_pkg::MUL_SHIFTADD) begin : g_shiftadd
         logic [W-1:0] part [W+1];
         assign part[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            assign part[i+1] = part[i] + (b_i[i] ? (a_i << i) : '0);
         end
         assign p_o = part[W];
      end else begin : g_native
         assign p_o = a_i * b_i;
      end
   endgenerate
endmodule

// File: rtl/seq_int_pow.sv
module seq_int_pow #(
   parameter int WIDTH     = 16,
   parameter int MULT_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] base_i,
   input  logic [WIDTH-1:0] exp_i,
   input  logic             base_signed_i,
   input  logic             exp_signed_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] result_o,
   output logic             undef_o
);
   import ipow_pkg::*;

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_int_pow: WIDTH must be at least 2");
      end
      if (MULT_IMPL != MUL_NATIVE && MULT_IMPL != MUL_SHIFTADD) begin : g_bad_impl
         $error("seq_int_pow: MULT_IMPL must be 0 or 1");
      end
   endgenerate

   ipow_state_e      state_q;
   logic [WIDTH-1:0] acc_q, sq_q, pw_q, res_q;
   logic             flip_q, und_pend_q, undef_q, done_q;

   logic             dec_iter, dec_undef, dec_flip;
   logic [WIDTH-1:0] dec_fixed, dec_mag, dec_pow;
   logic [WIDTH-1:0] prod_acc, prod_sq;

   ipow_decode #(.W(WIDTH)) u_decode (
      .base_i     (base_i),
      .exp_i      (exp_i),
      .base_sgn_i (base_signed_i),
      .exp_sgn_i  (exp_signed_i),
      .iter_o     (dec_iter),
      .fixed_o    (dec_fixed),
      .undef_o    (dec_undef),
      .mag_o      (dec_mag),
      .pow_o      (dec_pow),
      .flip_o     (dec_flip)
   );

   ipow_mul #(.W(WIDTH), .IMPL(MULT_IMPL)) u_mul_acc (
      .a_i (acc_q),
      .b_i (sq_q),
      .p_o (prod_acc)
   );

   ipow_mul #(.W(WIDTH), .IMPL(MULT_IMPL)) u_mul_sq (
      .a_i (sq_q),
      .b_i (sq_q),
      .p_o (prod_sq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         acc_q      <= '0;
         sq_q       <= '0;
         pw_q       <= '0;
         res_q      <= '0;
         flip_q     <= 1'b0;
         und_pend_q <= 1'b0;
         undef_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (dec_iter) begin
                     acc_q      <= ONE;
                     sq_q       <= dec_mag;
                     pw_q       <= dec_pow;
                     flip_q     <= dec_flip;
                     und_pend_q <= 1'b0;
                     state_q    <= ST_LOOP;
                  end else begin
                     acc_q      <= dec_fixed;
                     flip_q     <= 1'b0;
                     und_pend_q <= dec_undef;
                     state_q    <= ST_FIN;
                  end
               end
            end
            ST_LOOP: begin
               if (pw_q[0])
                  acc_q <= prod_acc;
               sq_q <= prod_sq;
               pw_q <= pw_q >> 1;
               if ((pw_q >> 1) == '0)
                  state_q <= ST_FIN;
            end
            ST_FIN: begin
               res_q   <= flip_q ? (~acc_q + ONE) : acc_q;
               undef_q <= und_pend_q;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign result_o = res_q;
   assign undef_o  = undef_q;
endmodule

// File: rtl/ipow_chk.sv
module ipow_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] result_o,
   input logic         undef_o
);
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R2
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      undef_o |-> (result_o == '0));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> ($stable(result_o) && $stable(undef_o)) || done_o);
endmodule

bind seq_int_pow ipow_chk #(.W(WIDTH)) u_ipow_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .result_o (result_o),
   .undef_o  (undef_o)
);

// File: tb/seq_int_pow_test.sv
module seq_int_pow_test;
   localparam int W = 4;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] base_i = '0;
   logic [W-1:0] exp_i = '0;
   logic         base_signed_i = 1'b0;
   logic         exp_signed_i = 1'b0;
   logic         busy_o, done_o, undef_o;
   logic [W-1:0] result_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   seq_int_pow #(.WIDTH(W), .MULT_IMPL(1)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .base_i        (base_i),
      .exp_i         (exp_i),
      .base_signed_i (base_signed_i),
      .exp_signed_i  (exp_signed_i),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .result_o      (result_o),
      .undef_o       (undef_o)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int to_int(input int raw, input bit sgn);
      return (sgn && raw >= M / 2) ? raw - M : raw;
   endfunction

   function automatic int ref_pow(input int a, input int b, output bit und);
      int y;
      und = 1'b0;
      if (a == 0 && b < 0) begin und = 1'b1; return 0; end
      if (b == 0) return 1;
      if (a == 0) return 0;
      if (b < 0) begin
         if (a == 1) return 1;
         if (a == -1) return (b % 2 == 0) ? 1 : M - 1;
         return 0;
      end
      y = 1;
      for (int i = 0; i < b; i++) y = (((y * a) % M) + M) % M;
      return y;
   endfunction

   function automatic int bitlen(input int v);
      int n = 0;
      while (v > 0) begin n++; v = v >> 1; end
      return n;
   endfunction

   task automatic run_op(input int a_raw, input int b_raw, input bit as, input bit bs,
                         input bit disturb, output int res, output int und,
                         output int lat, output int busy_bad);
      int cnt = 0;
      busy_bad = 0;
      @(negedge clk);
      base_i = W'(a_raw);
      exp_i = W'(b_raw);
      base_signed_i = as;
      exp_signed_i = bs;
      start_i = 1'b1;
      do begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (cnt == 1) begin
            if (disturb) begin
               base_i = W'(5);
               exp_i = W'(2);
               base_signed_i = 1'b0;
               exp_signed_i = 1'b0;
            end else begin
               start_i = 1'b0;
            end
         end
         if (!done_o && !busy_o) busy_bad++;
      end while (!done_o && cnt < 40);
      start_i = 1'b0;
      res = int'(result_o);
      und = int'(undef_o);
      lat = cnt;
      if (busy_o) busy_bad++;
   endtask

   initial begin
      int res, und, lat, bb, exp_r, exp_l, a, b;
      bit exp_u;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", int'(busy_o), 0);
      chk("R10 done", int'(done_o), 0);
      chk("R10 result", int'(result_o), 0);
      chk("R10 undef", int'(undef_o), 0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R6 R7: full sweep over operands and both flags
      for (int f = 0; f < 4; f++) begin
         for (int ar = 0; ar < M; ar++) begin
            for (int br = 0; br < M; br++) begin
               a = to_int(ar, f[0]);
               b = to_int(br, f[1]);
               exp_r = ref_pow(a, b, exp_u);
               exp_l = (a != 0 && b > 0) ? bitlen(b) + 2 : 2;
               run_op(ar, br, f[0], f[1], 1'b0, res, und, lat, bb);
               if (exp_u) chk("R2 undefined result", res, 0);
               else if (b <= 0 || a == 0) chk("R3/R4 closed form", res, exp_r);
               else chk("R5 power value (R1 reading)", res, exp_r);
               chk("R2 undef flag", und, int'(exp_u));
               chk("R6 latency", lat, exp_l);
               chk("R7 busy window", bb, 0);
            end
         end
      end

      // R8: start held high and operands changed while busy
      run_op(3, 7, 1'b0, 1'b0, 1'b1, res, und, lat, bb);
      chk("R8 result kept", res, 11);
      chk("R8 latency kept", lat, 5);

      // R9 / R7: outputs hold and done stays low with inputs moving
      base_i = W'(2);
      exp_i = W'(3);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R7 done single", int'(done_o), 0);
         chk("R9 result held", int'(result_o), 11);
      end

      // R3 zero to the zero, R4 minus one odd negative exponent
      run_op(0, 0, 1'b1, 1'b1, 1'b0, res, und, lat, bb);
      chk("R3 zero pow zero", res, 1);
      run_op(M - 1, M - 3, 1'b1, 1'b1, 1'b0, res, und, lat, bb);
      chk("R4 minus one odd", res, M - 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule